// File: doc/BRIEF.md
# 16-bit Capture/Reload Timer

This block is a 16-bit timer/counter paired with a 16-bit capture/reload register. It steps either on a fixed fraction of the input clock or on falling edges seen on an external count pin. A second external pin, the trigger, is used in one of three ways depending on the mode: it can latch the count, force a reload, or set the counting direction. The three modes are capture, auto-reload and baud generation. Auto-reload counts up, or counts up and down when down-counting is enabled. Baud generation produces a one-clock tick for a serial port on every rollover.

Software reaches the block through a small register port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The register map is:
- Address 0: the live count.
- Address 1: the shared capture/reload value.
- Address 2: the 9-bit control word.

The control word holds the mode selects, the run bit, and two sticky flags, overflow and external. An interrupt request is driven from these flags. All pins are plain level signals. No interface here carries a data stream, so none uses a handshake.

Top module: `cr_timer16`

## Requirements
- R1: After reset the count, the capture/reload value and the whole control word read as zero, and `irq` and `baud_tick` are low.
- R2: With control bit 0 (run) set and bit 1 (source) clear, the count steps exactly once in every 12 input clocks (one machine cycle). With run clear, the count holds its value.
- R3: With source set, the count pin is sampled once per machine cycle. Each high sample followed by a low sample steps the count once, provided the pin holds each level for at least one machine cycle.
- R4: Capture mode is control bit 8 set with bits 4 and 5 clear. In this mode, stepping from 0xFFFF wraps to 0x0000 and sets the overflow flag (control bit 6).
- R5: In capture mode with the external-enable bit set (bit 2), a trigger falling edge copies the count into the capture/reload register and sets the external flag (bit 7). With bit 2 clear, the edge changes neither the count, the register nor the flags.
- R6: In up-count reload mode (bits 8, 4, 5 and 3 clear), stepping from 0xFFFF loads the reload value and sets the overflow flag.
- R7: In up-count reload mode with bit 2 set, a trigger falling edge loads the count from the reload value and sets the external flag.
- R8: In reload mode with bit 3 (down enable) set, the trigger level selects direction: 1 counts up, 0 counts down. Stepping down from a count equal to the reload value loads 0xFFFF. Stepping up from 0xFFFF loads the reload value. Both events set the overflow flag and toggle the external flag. Trigger edges neither reload nor set the flag in this mode.
- R9: `irq` is high when the overflow flag is set. It is also high when the external flag is set, except in up/down mode, where the external flag never raises it.
- R10: Bit 4 or bit 5 set selects baud mode, which overrides bit 8. The count steps once every 2 clocks. A step from 0xFFFF reloads and pulses `baud_tick` for one clock, so ticks are (0x10000 - reload) * 2 clocks apart. The overflow flag is never set in baud mode. A trigger falling edge with bit 2 set sets the external flag without reloading.
- R11: Flags stay set until software writes 0 to them. When a hardware set and a software clear hit the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 capture/reload, 2 control) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, combinational |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External trigger / direction pin |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse per rollover in baud mode |

## Verification
A wrong prescaler phase or step gate shows up directly as a count that is off after a window of whole machine cycles. The bench therefore compares the count against an exact step count at the end of each window, independent of phase. A wrong reload, capture or direction decision changes the count or the capture register at the first boundary crossing, within one step of the event. Flag and interrupt errors show in the control read and on `irq` one clock after the event. Baud reload errors change the measured interval between two consecutive ticks.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_CTRL   = 2'd2
  } reg_addr_e;

  // Control word, bit 8 down to bit 0.
  typedef struct packed {
    logic cap_sel;   // 8
    logic ext_flag;  // 7
    logic ovf_flag;  // 6
    logic rx_sel;    // 5
    logic tx_sel;    // 4
    logic down_en;   // 3
    logic ext_en;    // 2
    logic src_ext;   // 1
    logic run;       // 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/crt_prescale.sv
module crt_prescale #(
  parameter int MC_DIV = 12,
  parameter int ST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic mc_tick,
  output logic st_tick
);
  localparam int MW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
  localparam int SW = (ST_DIV > 1) ? $clog2(ST_DIV) : 1;

  logic [MW-1:0] mc_q;
  logic [SW-1:0] st_q;

  assign mc_tick = (mc_q == MW'(MC_DIV - 1));
  assign st_tick = (st_q == SW'(ST_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_q <= '0;
      st_q <= '0;
    end else begin
      mc_q <= mc_tick ? '0 : mc_q + 1'b1;
      st_q <= st_tick ? '0 : st_q + 1'b1;
    end
  end
endmodule

// File: rtl/crt_pin_sampler.sv
module crt_pin_sampler #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic [NPINS-1:0] pins,
  output logic [NPINS-1:0] level,
  output logic [NPINS-1:0] fall
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [1:0] sync_q;
    logic       lvl_q;
    logic       fall_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q <= '0;
        lvl_q  <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], pins[g]};
        if (sample) begin
          lvl_q  <= sync_q[1];
          fall_q <= lvl_q & ~sync_q[1];
        end else begin
          fall_q <= 1'b0;
        end
      end
    end

    assign level[g] = lvl_q;
    assign fall[g]  = fall_q;
  end
endmodule

// File: rtl/cr_timer16.sv
module cr_timer16 #(
  parameter int DATA_W = 16,
  parameter int MC_DIV = 12,
  parameter int ST_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  output logic              irq,
  output logic              baud_tick
);
  import crt_pkg::*;

  localparam logic [DATA_W-1:0] TOP = '1;

  logic              mc_tick, st_tick;
  logic [1:0]        pin_lvl, pin_fall;
  logic [DATA_W-1:0] count_q, count_n, reload_q, reload_n;
  ctrl_t             ctrl_q, ctrl_n;
  logic              baud_n;
  logic              baud_mode, updown, step, trig_fall, trig_lvl;
  logic              ovf_evt, ext_set, ext_tog;
  logic              wr_count, wr_reload, wr_ctrl;

  crt_prescale #(.MC_DIV(MC_DIV), .ST_DIV(ST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .st_tick(st_tick)
  );

  crt_pin_sampler #(.NPINS(2)) u_smp (
    .clk(clk), .rst_n(rst_n), .sample(mc_tick),
    .pins({trig_pin, cnt_pin}), .level(pin_lvl), .fall(pin_fall)
  );

  assign trig_lvl  = pin_lvl[1];
  assign trig_fall = pin_fall[1];
  assign baud_mode = ctrl_q.tx_sel | ctrl_q.rx_sel;
  assign updown    = ~baud_mode & ~ctrl_q.cap_sel & ctrl_q.down_en;
  assign step      = ctrl_q.run &
                     (ctrl_q.src_ext ? pin_fall[0] : (baud_mode ? st_tick : mc_tick));
  assign wr_count  = wr_en && (wr_addr == ADDR_COUNT);
  assign wr_reload = wr_en && (wr_addr == ADDR_RELOAD);
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);

  always_comb begin
    count_n  = count_q;
    reload_n = reload_q;
    ovf_evt  = 1'b0;
    ext_set  = 1'b0;
    ext_tog  = 1'b0;
    baud_n   = 1'b0;
    if (step) begin
      if (baud_mode) begin
        if (count_q == TOP) begin
          count_n = reload_q;
          baud_n  = 1'b1;
        end else count_n = count_q + 1'b1;
      end else if (ctrl_q.cap_sel) begin
        count_n = count_q + 1'b1;
        ovf_evt = (count_q == TOP);
      end else if (updown && !trig_lvl) begin
        if (count_q == reload_q) begin
          count_n = TOP;
          ovf_evt = 1'b1;
          ext_tog = 1'b1;
        end else count_n = count_q - 1'b1;
      end else begin
        if (count_q == TOP) begin
          count_n = reload_q;
          ovf_evt = 1'b1;
          ext_tog = updown;
        end else count_n = count_q + 1'b1;
      end
    end
    if (trig_fall && ctrl_q.ext_en && !updown) begin
      ext_set = 1'b1;
      if (!baud_mode) begin
        if (ctrl_q.cap_sel) reload_n = count_q;
        else                count_n  = reload_q;
      end
    end
    if (wr_count)  count_n  = wr_data;
    if (wr_reload) reload_n = wr_data;

    ctrl_n = wr_ctrl ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    if (ovf_evt) ctrl_n.ovf_flag = 1'b1;
    if (ext_set)      ctrl_n.ext_flag = 1'b1;
    else if (ext_tog) ctrl_n.ext_flag = ~ctrl_q.ext_flag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      reload_q  <= '0;
      ctrl_q    <= '0;
      baud_tick <= 1'b0;
    end else begin
      count_q   <= count_n;
      reload_q  <= reload_n;
      ctrl_q    <= ctrl_n;
      baud_tick <= baud_n;
    end
  end

  assign irq = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~updown);

  always_comb begin
    case (rd_addr)
      ADDR_COUNT:  rd_data = count_q;
      ADDR_RELOAD: rd_data = reload_q;
      ADDR_CTRL:   rd_data = DATA_W'(ctrl_q);
      default:     rd_data = '0;
    endcase
  end
endmodule

// File: rtl/crt_timer_chk.sv
module crt_timer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] reload_q,
  input logic [8:0]        ctrl_bits,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic              trig_fall,
  input logic              ovf_evt,
  input logic              irq,
  input logic              baud_tick
);
  logic run, ext_en, down_en, baud, cap_sel, ovf_flag, updown;
  assign run      = ctrl_bits[0];
  assign ext_en   = ctrl_bits[2];
  assign down_en  = ctrl_bits[3];
  assign baud     = ctrl_bits[4] | ctrl_bits[5];
  assign ovf_flag = ctrl_bits[6];
  assign cap_sel  = ctrl_bits[8];
  assign updown   = !baud && !cap_sel && down_en;

  assert_frozen_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig_fall && !(wr_en && wr_addr == 2'd0)) |=> $stable(count_q));

  assert_capture_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && ext_en && cap_sel && !baud && !(wr_en && wr_addr == 2'd1))
      |=> (reload_q == $past(count_q)));

  assert_updown_ext_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (updown && !ovf_flag) |-> !irq);

  assert_baud_no_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ovf_flag && !(wr_en && wr_addr == 2'd2)) |=> !ovf_flag);

  assert_tick_only_baud_R10: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(baud));

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
endmodule

bind cr_timer16 crt_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_q(count_q), .reload_q(reload_q),
  .ctrl_bits(ctrl_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .trig_fall(trig_fall), .ovf_evt(ovf_evt), .irq(irq), .baud_tick(baud_tick)
);

// File: tb/cr_timer16_tb.sv
module cr_timer16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cnt_pin = 1'b0;
  logic        trig_pin = 1'b1;
  logic        irq, baud_tick;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cr_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .irq(irq), .baud_tick(baud_tick)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] up_model(input logic [15:0] c, input logic [15:0] rel, input int k);
    for (int i = 0; i < k; i++) c = (c == 16'hFFFF) ? rel : c + 16'd1;
    return c;
  endfunction

  function automatic int baud_period(input logic [15:0] rel);
    return (32'h10000 - int'(rel)) * 2;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4321));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 16'h0);
    rd(2'd1, v); check("R1 reload", v, 16'h0);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0);
    check("R1 irq/tick", {14'b0, irq, baud_tick}, 16'h0);

    // R6 up reload overflow (ctrl run=1)
    wr(2'd1, 16'h2000);
    wr(2'd0, 16'hFFFC);
    wr(2'd2, 16'h0001);
    wait_clk(12 * 10 - 1);
    rd(2'd0, v); check("R6 reload after 10 steps", v, 16'h2006);
    rd(2'd2, v); check("R6 ovf flag", v, 16'h0041);
    check("R9 irq on ovf", {15'b0, irq}, 16'h1);

    // R2 freeze + R11 persistence
    wr(2'd2, 16'h0040);
    rd(2'd0, v);
    begin
      logic [15:0] held;
      held = v;
      wait_clk(100);
      rd(2'd0, v); check("R2 frozen with run clear", v, held);
    end
    rd(2'd2, v); check("R11 flag persists", v, 16'h0040);
    wr(2'd2, 16'h0000);
    check("R11 sw clear drops irq", {15'b0, irq}, 16'h0);

    // R2 random windows in up reload mode
    for (int i = 0; i < 6; i++) begin
      logic [15:0] rel, c;
      int k;
      rel = 16'($urandom);
      c   = 16'hFFFF - 16'($urandom % 12);
      k   = 1 + int'($urandom % 16);
      wr(2'd1, rel);
      wr(2'd0, c);
      wr(2'd2, 16'h0001);
      wait_clk(12 * k - 1);
      rd(2'd0, v); check("R2 step rate / R6 model", v, up_model(c, rel, k));
      wr(2'd2, 16'h0000);
    end

    // R4 capture mode overflow
    wr(2'd0, 16'hFFFE);
    wr(2'd2, 16'h0101);
    wait_clk(12 * 4 - 1);
    rd(2'd0, v); check("R4 wrap to zero", v, 16'h0002);
    rd(2'd2, v); check("R4 ovf flag", v, 16'h0141);
    wr(2'd2, 16'h0000);

    // R3 external count pin
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0003);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b1; wait_clk(24);
      cnt_pin = 1'b0; wait_clk(24);
    end
    wait_clk(48);
    rd(2'd0, v); check("R3 counted falling edges", v, 16'h0005);
    wr(2'd2, 16'h0000);

    // R5 capture on trigger
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h1234);
    wr(2'd2, 16'h0104);
    trig_pin = 1'b0; wait_clk(40);
    rd(2'd1, v); check("R5 captured count", v, 16'h1234);
    rd(2'd2, v); check("R5 ext flag", v, 16'h0184);
    check("R9 irq on ext", {15'b0, irq}, 16'h1);
    // R5 ignored when external enable clear
    wr(2'd2, 16'h0100);
    wr(2'd0, 16'h4321);
    trig_pin = 1'b1; wait_clk(40);
    trig_pin = 1'b0; wait_clk(40);
    rd(2'd1, v); check("R5 no capture when disabled", v, 16'h1234);
    rd(2'd2, v); check("R5 no flag when disabled", v, 16'h0100);
    rd(2'd0, v); check("R5 count untouched", v, 16'h4321);

    // R7 reload on trigger
    trig_pin = 1'b1;
    wr(2'd2, 16'h0004);
    wr(2'd1, 16'hABCD);
    wr(2'd0, 16'h0055);
    wait_clk(40);
    trig_pin = 1'b0; wait_clk(40);
    rd(2'd0, v); check("R7 trigger reload", v, 16'hABCD);
    rd(2'd2, v); check("R7 ext flag", v, 16'h0084);

    // R8 down counting (trigger low)
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h1000);
    wr(2'd0, 16'h1003);
    wr(2'd2, 16'h0009);
    wait_clk(12 * 5 - 1);
    rd(2'd0, v); check("R8 underflow loads FFFF", v, 16'hFFFE);
    rd(2'd2, v); check("R8 ovf set, ext toggled", v, 16'h00C9);
    wr(2'd2, 16'h0088);
    check("R9 ext silent in up/down", {15'b0, irq}, 16'h0);
    // R8 up direction with trigger high
    trig_pin = 1'b1; wait_clk(40);
    rd(2'd0, v); check("R8 trigger edge no reload", v, 16'hFFFE);
    wr(2'd2, 16'h0089);
    wait_clk(12 * 3 - 1);
    rd(2'd0, v); check("R8 up overflow reload", v, 16'h1001);
    rd(2'd2, v); check("R8 ext toggled back", v, 16'h0049);
    wr(2'd2, 16'h0000);

    // R10 baud mode tick spacing
    for (int i = 0; i < 6; i++) begin
      logic [15:0] rel;
      int t0, t1;
      rel = 16'hFFFF - 16'($urandom % 40);
      wr(2'd1, rel);
      wr(2'd0, rel);
      wr(2'd2, ($urandom % 2) ? 16'h0011 : 16'h0021);
      while (!baud_tick) @(negedge clk);
      t0 = cyc;
      @(negedge clk);
      while (!baud_tick) @(negedge clk);
      t1 = cyc;
      check("R10 tick spacing", 16'(t1 - t0), 16'(baud_period(rel)));
      rd(2'd2, v); check("R10 no ovf flag", v & 16'h0040, 16'h0);
      wr(2'd2, 16'h0000);
    end

    // R10 trigger in baud mode: flag only
    trig_pin = 1'b1;
    wr(2'd1, 16'h8000);
    wr(2'd0, 16'h0100);
    wr(2'd2, 16'h0014);
    wait_clk(40);
    trig_pin = 1'b0; wait_clk(40);
    rd(2'd0, v); check("R10 trigger no reload", v, 16'h0100);
    rd(2'd2, v); check("R10 trigger sets ext", v, 16'h0094);

    finish_run();
  end
endmodule